// File: doc/BRIEF.md
# Converter Calibrate/Convert Sequencer

This block is the control state machine of a two-input converter. It runs on the master clock and moves between five reported states: a wake-up delay after reset, standby, a two-step calibration (offset step, then gain step) and conversion. Commands arrive on two level inputs. A rising edge of the convert input is a command. If the calibrate input is high at that edge, the command is a calibration; if it is low, the command is a conversion. The channel-select input is captured on each accepted edge.

When a conversion ends, the block takes a raw, signed, calibrated result from the filter. It adds the bipolar offset if bipolar mode is selected, clamps the sum to the 20-bit code range, and emits a one-cycle done pulse. The pulse carries the formatted word, the captured channel and the mode that was applied. The bipolar selection is not captured on the command edge. It is sampled a fixed number of cycles before the end of the conversion, so software can change it while a conversion is running.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `seq_state` reads 0 (wake-up) for WAKE_CYC cycles, then 1 (standby) when no command is pending. The state never returns to wake-up without a reset.
- R2: A convert rising edge seen during wake-up is held and executed when wake-up ends. A conversion requested this way completes WAKE_CYC + CONV_FIRST_CYC cycles after reset is released.
- R3: A convert rising edge with calibrate high starts a calibration of CAL_CYC cycles. `seq_state` reads 2 for the first CAL_CYC/2 cycles and 3 for the rest. The calibration ends with a `cal_done` pulse lasting exactly one cycle.
- R4: At the end of calibration, the block enters conversion (state 4) if the convert input is high, and standby (state 1) otherwise.
- R5: During calibration, a convert rising edge with calibrate high restarts calibration from the offset step and captures the channel. A convert rising edge with calibrate low changes neither the timing nor the captured channel.
- R6: In standby, a convert rising edge with calibrate low starts a conversion and captures `chan_sel` (0 = first input, 1 = second input) on `chan_latched`. The result appears CONV_FIRST_CYC cycles after that edge.
- R7: While the convert input stays high, each following conversion takes CONV_NEXT_CYC cycles. After the convert input falls, the conversion in progress still completes and the block then returns to standby.
- R8: A convert rising edge during a conversion discards the running conversion without a result and starts a new one of CONV_FIRST_CYC cycles with a newly captured channel.
- R9: `bipolar_sel` is sampled BP_LEAD_CYC cycles before a conversion completes. A change made before that point is applied; a change made after it affects only the next result.
- R10: The output word is the raw result plus 0x80000 in bipolar mode, or the raw result alone in unipolar mode. A sum above 0xFFFFF gives 0xFFFFF and a negative sum gives 0x00000.
- R11: `conv_done` lasts one cycle and carries the word, the captured channel and the applied mode. `conv_done` and `cal_done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibrate level; qualifies a convert edge as a calibration |
| conv_req | input | 1 | Convert level; a rising edge is a command |
| chan_sel | input | 1 | Channel select, captured on an accepted command edge |
| bipolar_sel | input | 1 | 1 = bipolar result format, sampled near the end of a conversion |
| raw_result | input | 22 | Signed calibrated result from the filter |
| seq_state | output | 3 | 0 wake-up, 1 standby, 2 offset calibration, 3 gain calibration, 4 conversion |
| chan_latched | output | 1 | Currently captured channel |
| cal_done | output | 1 | One-cycle pulse at the end of calibration |
| conv_done | output | 1 | One-cycle pulse with a new result |
| conv_word | output | 20 | Formatted, saturated result |
| conv_chan | output | 1 | Channel of the result |
| conv_bipolar | output | 1 | Format applied to the result |

## Verification
The assertions check on every cycle that:
- wake-up is left only once;
- the offset step always runs into the gain step unless a restart occurs;
- a convert edge with calibrate low leaves the gain step in place;
- both done pulses last a single cycle and never coincide;
- calibration always exits to standby or conversion.

Only the bench scenarios can show the cycle timing: wake-up deferral, the first and back-to-back conversion lengths, restart and abort timing, and the bipolar sampling window. The same applies to the arithmetic of the offset and saturation at each edge of the code range. The bench checks all of these against a scoreboard of expected completion cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W = 20;

    typedef enum logic [2:0] {
        SEQ_WAKE     = 3'd0,
        SEQ_IDLE     = 3'd1,
        SEQ_CAL_OFS  = 3'd2,
        SEQ_CAL_GAIN = 3'd3,
        SEQ_CONV     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [RES_W-1:0] word;
        logic             chan;
        logic             bipolar;
    } conv_result_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_cmd_edge.sv
module adc_cmd_edge (
    input  logic clk,
    input  logic rst,
    input  logic conv_lvl,
    output logic conv_rise
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b0;
        else     conv_q <= conv_lvl;
    end

    // A level already high when reset is released counts as a command.
    assign conv_rise = conv_lvl & ~conv_q;
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int RES_W = 20
) (
    input  logic signed [RES_W+1:0] raw,
    input  logic                    bipolar,
    output logic [RES_W-1:0]        code
);
    localparam int EXT_W = RES_W + 3;

    logic signed [EXT_W-1:0] raw_ext;
    logic signed [EXT_W-1:0] ofs;
    logic signed [EXT_W-1:0] sum;

    always_comb begin
        raw_ext = EXT_W'(raw);
        ofs = '0;
        ofs[RES_W-1] = bipolar;
        sum = raw_ext + ofs;
        if (sum[EXT_W-1])
            code = '0;
        else if (|sum[EXT_W-2:RES_W])
            code = '1;
        else
            code = sum[RES_W-1:0];
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int WAKE_CYC       = 1800,
    parameter int CAL_CYC        = 3246,
    parameter int CONV_FIRST_CYC = 1624,
    parameter int CONV_NEXT_CYC  = 1622,
    parameter int BP_LEAD_CYC    = 82,
    parameter int CNT_W          = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_lvl,
    input  logic       conv_lvl,
    input  logic       conv_rise,
    input  logic       chan_in,
    input  logic       bp_in,
    output seq_state_e state,
    output logic       chan_q,
    output logic       bp_q,
    output logic       cal_fire,
    output logic       conv_fire
);
    localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LD   = CNT_W'(CAL_CYC - 1);
    localparam logic [CNT_W-1:0] FIRST_LD = CNT_W'(CONV_FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] NEXT_LD  = CNT_W'(CONV_NEXT_CYC - 1);
    localparam logic [CNT_W-1:0] GAIN_AT  = CNT_W'(CAL_CYC - CAL_CYC / 2);
    localparam logic [CNT_W-1:0] BP_AT    = CNT_W'(BP_LEAD_CYC);

    logic [CNT_W-1:0] cnt;
    logic cnt_zero, pend_conv, pend_cal;
    logic go_cal, go_conv, go_next, go_idle, latch_chan;
    logic in_cal;

    assign cnt_zero = (cnt == '0);
    assign in_cal   = (state == SEQ_CAL_OFS) || (state == SEQ_CAL_GAIN);

    always_comb begin
        go_cal = 1'b0; go_conv = 1'b0; go_next = 1'b0;
        go_idle = 1'b0; latch_chan = 1'b0;
        unique case (state)
            SEQ_WAKE: begin
                latch_chan = conv_rise;
                if (cnt_zero) begin
                    if (conv_rise) begin
                        go_cal = cal_lvl; go_conv = !cal_lvl;
                    end else if (pend_conv) begin
                        go_cal = pend_cal; go_conv = !pend_cal;
                    end else begin
                        go_idle = 1'b1;
                    end
                end
            end
            SEQ_IDLE: begin
                if (conv_rise) begin
                    latch_chan = 1'b1; go_cal = cal_lvl; go_conv = !cal_lvl;
                end
            end
            SEQ_CAL_OFS, SEQ_CAL_GAIN: begin
                if (conv_rise && cal_lvl) begin
                    latch_chan = 1'b1; go_cal = 1'b1;
                end else if (cnt_zero) begin
                    go_conv = conv_lvl; go_idle = !conv_lvl;
                end
            end
            SEQ_CONV: begin
                if (conv_rise) begin
                    latch_chan = 1'b1; go_cal = cal_lvl; go_conv = !cal_lvl;
                end else if (cnt_zero) begin
                    go_next = conv_lvl; go_idle = !conv_lvl;
                end
            end
            default: go_idle = 1'b1;
        endcase
    end

    assign cal_fire  = in_cal && cnt_zero && !(conv_rise && cal_lvl);
    assign conv_fire = (state == SEQ_CONV) && cnt_zero && !conv_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_WAKE;
            cnt       <= WAKE_LD;
            pend_conv <= 1'b0;
            pend_cal  <= 1'b0;
            chan_q    <= 1'b0;
            bp_q      <= 1'b0;
        end else begin
            if (latch_chan) chan_q <= chan_in;
            if (state == SEQ_WAKE && conv_rise) begin
                pend_conv <= 1'b1;
                pend_cal  <= cal_lvl;
            end
            if (state == SEQ_WAKE && cnt_zero) begin
                pend_conv <= 1'b0;
                pend_cal  <= 1'b0;
            end
            if (go_cal) begin
                state <= SEQ_CAL_OFS;
                cnt   <= CAL_LD;
            end else if (go_conv) begin
                state <= SEQ_CONV;
                cnt   <= FIRST_LD;
            end else if (go_next) begin
                cnt <= NEXT_LD;
            end else if (go_idle) begin
                state <= SEQ_IDLE;
            end else begin
                if (!cnt_zero) cnt <= cnt - 1'b1;
                if (state == SEQ_CAL_OFS && cnt == GAIN_AT) state <= SEQ_CAL_GAIN;
            end
            if (state == SEQ_CONV && cnt == BP_AT) bp_q <= bp_in;
        end
    end

    // R1
    wake_once_chk: assert property (@(posedge clk) disable iff (rst)
        state != SEQ_WAKE |=> state != SEQ_WAKE);

    // R3
    ofs_to_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CAL_OFS && !conv_rise) |=>
            (state == SEQ_CAL_OFS || state == SEQ_CAL_GAIN));

    // R5
    cal_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CAL_GAIN && conv_rise && !cal_lvl && !cnt_zero) |=>
            state == SEQ_CAL_GAIN);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int WAKE_CYC       = 1800,
    parameter int CAL_CYC        = 3246,
    parameter int CONV_FIRST_CYC = 1624,
    parameter int CONV_NEXT_CYC  = 1622,
    parameter int BP_LEAD_CYC    = 82
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_req,
    input  logic                    conv_req,
    input  logic                    chan_sel,
    input  logic                    bipolar_sel,
    input  logic signed [RES_W+1:0] raw_result,
    output logic [2:0]              seq_state,
    output logic                    chan_latched,
    output logic                    cal_done,
    output logic                    conv_done,
    output logic [RES_W-1:0]        conv_word,
    output logic                    conv_chan,
    output logic                    conv_bipolar
);
    localparam int MAX_CYC = max2(max2(WAKE_CYC, CAL_CYC),
                                  max2(CONV_FIRST_CYC, CONV_NEXT_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic         conv_rise, chan_q, bp_q, cal_fire, conv_fire;
    seq_state_e   state;
    logic [RES_W-1:0] fmt_code;
    conv_result_t res_q;

    adc_cmd_edge u_edge (
        .clk(clk), .rst(rst), .conv_lvl(conv_req), .conv_rise(conv_rise)
    );

    adc_seq_core #(
        .WAKE_CYC(WAKE_CYC), .CAL_CYC(CAL_CYC),
        .CONV_FIRST_CYC(CONV_FIRST_CYC), .CONV_NEXT_CYC(CONV_NEXT_CYC),
        .BP_LEAD_CYC(BP_LEAD_CYC), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst(rst), .cal_lvl(cal_req), .conv_lvl(conv_req),
        .conv_rise(conv_rise), .chan_in(chan_sel), .bp_in(bipolar_sel),
        .state(state), .chan_q(chan_q), .bp_q(bp_q),
        .cal_fire(cal_fire), .conv_fire(conv_fire)
    );

    adc_result_fmt #(.RES_W(RES_W)) u_fmt (
        .raw(raw_result), .bipolar(bp_q), .code(fmt_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_done  <= 1'b0;
            conv_done <= 1'b0;
            res_q     <= '0;
        end else begin
            cal_done  <= cal_fire;
            conv_done <= conv_fire;
            if (conv_fire) begin
                res_q.word    <= fmt_code;
                res_q.chan    <= chan_q;
                res_q.bipolar <= bp_q;
            end
        end
    end

    assign seq_state    = state;
    assign chan_latched = chan_q;
    assign conv_word    = res_q.word;
    assign conv_chan    = res_q.chan;
    assign conv_bipolar = res_q.bipolar;

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && conv_done));

    // R11
    conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);

    // R3
    cal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);

    // R4
    cal_exit_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (seq_state == SEQ_IDLE || seq_state == SEQ_CONV));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    import adc_seq_pkg::*;

    localparam int WK = 1800, CL = 3246, FC = 1624, NC = 1622, BL = 82;
    localparam int OFS = CL / 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cal_req = 1'b0, conv_req = 1'b0, chan_sel = 1'b0, bipolar_sel = 1'b0;
    logic signed [21:0] raw_result = '0;
    logic [2:0] seq_state;
    logic chan_latched, cal_done, conv_done, conv_chan, conv_bipolar;
    logic [19:0] conv_word;

    adc_seq_ctrl uut (
        .clk(clk), .rst(rst), .cal_req(cal_req), .conv_req(conv_req),
        .chan_sel(chan_sel), .bipolar_sel(bipolar_sel), .raw_result(raw_result),
        .seq_state(seq_state), .chan_latched(chan_latched), .cal_done(cal_done),
        .conv_done(conv_done), .conv_word(conv_word), .conv_chan(conv_chan),
        .conv_bipolar(conv_bipolar)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct {
        int at; bit is_cal; logic [19:0] word; bit chan; bit bp; string tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [19:0] model(input int raw, input bit bp);
        int v;
        v = raw + (bp ? 524288 : 0);
        if (v < 0) return 20'h00000;
        if (v > 1048575) return 20'hFFFFF;
        return v[19:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int at, input bit is_cal, input int raw,
                        input bit ch, input bit bp, input string tag);
        exp_t e;
        e.at = at; e.is_cal = is_cal; e.word = model(raw, bp);
        e.chan = ch; e.bp = bp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(output int cr);
        rst = 1'b1; conv_req = 1'b0; cal_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cr = cyc;
    endtask

    task automatic single_conv(input int raw, input bit ch, input bit bp, input string tag);
        int s;
        raw_result = 22'(raw); chan_sel = ch; bipolar_sel = bp;
        conv_req = 1'b1; s = cyc + 1;
        push(s + FC, 1'b0, raw, ch, bp, tag);
        step_to(s + 3); conv_req = 1'b0;
        step_to(s + FC + 2);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() > 0 && cyc > sb[0].at) begin
                check(1'b0, sb[0].tag, "missing done at cycle", cyc, sb[0].at);
                void'(sb.pop_front());
            end
            if (conv_done || cal_done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11", "unexpected done pulse", cyc, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.at, e.tag, "done cycle", cyc, e.at);
                    check(cal_done == e.is_cal, e.tag, "pulse kind", cal_done, e.is_cal);
                    if (!e.is_cal) begin
                        check(conv_word == e.word, e.tag, "word", conv_word, e.word);
                        check(conv_chan == e.chan, e.tag, "channel", conv_chan, e.chan);
                        check(conv_bipolar == e.bp, e.tag, "mode", conv_bipolar, e.bp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cr, c, s, s2;
        @(negedge clk);

        // R1: wake-up then standby
        do_reset(cr);
        check(seq_state == 3'd0, "R1", "state after reset", seq_state, 0);
        step_to(cr + WK - 1);
        check(seq_state == 3'd0, "R1", "state at end of wake-up", seq_state, 0);
        step_to(cr + WK);
        check(seq_state == 3'd1, "R1", "standby after wake-up", seq_state, 1);

        // R2: command during wake-up is deferred
        do_reset(cr);
        step_to(cr + 10);
        raw_result = 22'(32'h12345); chan_sel = 1'b1; conv_req = 1'b1;
        step_to(cr + 20); conv_req = 1'b0; chan_sel = 1'b0;
        push(cr + WK + FC, 1'b0, 32'h12345, 1'b1, 1'b0, "R2");
        step_to(cr + WK - 1);
        check(seq_state == 3'd0, "R2", "still waking", seq_state, 0);
        step_to(cr + WK);
        check(seq_state == 3'd4, "R2", "deferred conversion", seq_state, 4);
        check(chan_latched == 1'b1, "R6", "captured channel", chan_latched, 1);
        step_to(cr + WK + FC + 2);
        check(seq_state == 3'd1, "R6", "standby after single", seq_state, 1);

        // R3: calibration from standby, back to standby
        c = cyc; cal_req = 1'b1; conv_req = 1'b1; s = c + 1;
        push(s + CL, 1'b1, 0, 1'b0, 1'b0, "R3");
        step_to(c + 5); cal_req = 1'b0; conv_req = 1'b0;
        step_to(s + OFS - 1);
        check(seq_state == 3'd2, "R3", "offset step", seq_state, 2);
        step_to(s + OFS);
        check(seq_state == 3'd3, "R3", "gain step", seq_state, 3);
        step_to(s + CL + 1);
        check(seq_state == 3'd1, "R4", "standby after calibration", seq_state, 1);

        // R5: restart with CAL high, ignore with CAL low; R4 chain
        c = cyc; chan_sel = 1'b1; cal_req = 1'b1; conv_req = 1'b1;
        step_to(c + 100); conv_req = 1'b0;
        step_to(c + 200); chan_sel = 1'b0; conv_req = 1'b1; s2 = c + 201;
        raw_result = -22'sd5;
        push(s2 + CL, 1'b1, 0, 1'b0, 1'b0, "R5");
        push(s2 + CL + FC, 1'b0, -5, 1'b0, 1'b0, "R4");
        step_to(c + 300);
        check(seq_state == 3'd2, "R5", "restarted offset step", seq_state, 2);
        cal_req = 1'b0; conv_req = 1'b0;
        step_to(c + 310); chan_sel = 1'b1; conv_req = 1'b1;
        step_to(s2 + OFS + 10);
        check(seq_state == 3'd3, "R5", "ignored edge keeps gain step", seq_state, 3);
        check(chan_latched == 1'b0, "R5", "ignored edge keeps channel", chan_latched, 0);
        step_to(s2 + CL + 1);
        check(seq_state == 3'd4, "R4", "chained conversion", seq_state, 4);
        step_to(s2 + CL + 5); conv_req = 1'b0;
        step_to(s2 + CL + FC + 2);

        // R7: back-to-back conversions
        raw_result = 22'(32'hABC); chan_sel = 1'b1; bipolar_sel = 1'b0;
        c = cyc; conv_req = 1'b1; s = c + 1;
        push(s + FC, 1'b0, 32'hABC, 1'b1, 1'b0, "R7");
        push(s + FC + NC, 1'b0, 32'hABC, 1'b1, 1'b0, "R7");
        push(s + FC + 2 * NC, 1'b0, 32'hABC, 1'b1, 1'b0, "R7");
        step_to(s + FC + NC + 5); conv_req = 1'b0;
        step_to(s + FC + 2 * NC + 3);
        check(seq_state == 3'd1, "R7", "standby after release", seq_state, 1);

        // R8: abort and restart
        raw_result = 22'(32'h55555); chan_sel = 1'b0;
        c = cyc; conv_req = 1'b1;
        step_to(c + 3); conv_req = 1'b0;
        step_to(c + 500); chan_sel = 1'b1; conv_req = 1'b1; s2 = c + 501;
        push(s2 + FC, 1'b0, 32'h55555, 1'b1, 1'b0, "R8");
        step_to(c + 505); conv_req = 1'b0;
        step_to(s2 + FC + 2);

        // R9: mode sampled late, not at the command edge
        raw_result = 22'(32'h1000); bipolar_sel = 1'b0; chan_sel = 1'b0;
        c = cyc; conv_req = 1'b1; s = c + 1;
        step_to(c + 3); conv_req = 1'b0;
        step_to(s + 100); bipolar_sel = 1'b1;
        push(s + FC, 1'b0, 32'h1000, 1'b0, 1'b1, "R9");
        step_to(s + FC + 2);
        c = cyc; conv_req = 1'b1; s = c + 1;
        push(s + FC, 1'b0, 32'h1000, 1'b0, 1'b1, "R9");
        step_to(c + 3); conv_req = 1'b0;
        step_to(s + FC - BL + 30); bipolar_sel = 1'b0;
        step_to(s + FC + 2);

        // R10: offset and saturation corners
        single_conv(-5, 1'b0, 1'b0, "R10");
        single_conv(32'h100003, 1'b1, 1'b0, "R10");
        single_conv(32'hFFFFF, 1'b1, 1'b0, "R10");
        single_conv(-524288, 1'b1, 1'b1, "R10");
        single_conv(-524289, 1'b0, 1'b1, "R10");
        single_conv(32'h7FFFF, 1'b1, 1'b1, "R10");
        single_conv(32'h80000, 1'b0, 1'b1, "R10");
        single_conv(32'h12, 1'b0, 1'b1, "R10");

        step_to(cyc + 5);
        check(sb.size() == 0, "R11", "outstanding results", sb.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule